// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Command Controller

This block drives a serial EEPROM over four pins: a select line, a shift clock, a serial output to the device and a serial input from it. A client hands it one request at a time on a valid/acknowledge interface. Each request is a read, a write-enable, a write or an erase, and it carries a word address, a 16-bit write word and a run-time choice of a 6-bit or 8-bit address field. The controller turns the request into a bit-serial frame. It clocks the frame out with a fixed phase length taken from a divider of the system clock. For a read it then clocks in a 16-bit word.

Programming commands (write and erase) need one more step. After the frame the controller drops select for one phase and raises it again. It then samples the device's serial output at a fixed poll interval until the device reports ready. If the device does not report ready within a bounded number of polls, the controller gives up and raises a timeout flag. Every command, programming or not, ends with select low. A write-enable issued before a write is therefore separated from that write by a select low period.

Top module: `sprom_ctrl`

## Requirements
- R1: A frame starts with a 1 bit and then two opcode bits: read `10`, write-enable `00`, write `01`, erase `11`. The request codes are `req_op` 0 = read, 1 = write-enable, 2 = write, 3 = erase. The address follows MSB first. It is 8 bits when `addr_wide` is 1 and the low 6 bits of `req_addr` when it is 0, so a frame has 9 or 11 command bits.
- R2: For write-enable, every address bit on the wire is 1, whatever `req_addr` holds.
- R3: A write sends the 16-bit `req_wdata` MSB first right after the address. Read frames send 16 zero bits while the data comes in.
- R4: A read samples `rom_miso` once per data bit, at the end of that bit's clock-high phase, MSB first. The 16-bit result is on `rdata` when `done` pulses.
- R5: With select high, each clock-low phase and each clock-high phase lasts exactly `PHASE_CYC` system clocks. `rom_mosi` changes only while the clock is low.
- R6: Select goes low at the end of every command and is low when `done` pulses. A programming command raises select exactly twice: once for the frame and once for polling. Any other command raises it once.
- R7: After a write or erase frame, select stays low for exactly `PHASE_CYC` clocks and is then high while polling. `rom_miso` is checked every `POLL_CYC` clocks. The first check that reads 1 ends polling, so the polling stretch is a whole number of intervals and `timeout` stays 0.
- R8: If `POLL_MAX` checks all read 0, polling ends after `POLL_MAX*POLL_CYC` clocks and `timeout` goes to 1 before `done`. `timeout` holds until the next accepted request clears it.
- R9: `req_ack` is high only in a cycle in which `req_valid` is high and the block is idle. `busy` follows from the next cycle until `done`. Requests made while busy get no acknowledge and do not change the frame in progress.
- R10: After reset, select, clock, serial output, `busy`, `done` and `timeout` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | 0 read, 1 write-enable, 2 write, 3 erase |
| req_addr | input | 8 | Word address (low 6 bits used in narrow mode) |
| req_wdata | input | 16 | Word to program on a write |
| addr_wide | input | 1 | 1 = 8-bit address field, 0 = 6-bit |
| req_ack | output | 1 | Request accepted this cycle |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle pulse at command end |
| timeout | output | 1 | Last programming command never saw ready |
| rdata | output | 16 | Word returned by the last read |
| rom_sel | output | 1 | Device select |
| rom_sclk | output | 1 | Shift clock |
| rom_mosi | output | 1 | Serial data to the device |
| rom_miso | input | 1 | Serial data and ready status from the device |

## Verification
Reads are run in both address widths. One read uses an address whose upper bits must be dropped in narrow mode, and its data word has both end bits set, so a bit-order or width fault shows in the captured frame or in `rdata`. Write-enable is run with an address that is not all ones, to separate the forced field from the passed-through one. Writes are run against a device that is ready at once and one that becomes ready partway through the third poll interval; the first must poll for one interval and the second for three. An erase against a device that never becomes ready covers the timeout, and a read after it checks that the flag clears. One read is also flooded with conflicting requests while busy.

// File: rtl/sprom_pkg.sv
package sprom_pkg;

    localparam int DW        = 16;
    localparam int AW_NARROW = 6;
    localparam int AW_WIDE   = 8;
    localparam int HDR_W     = 3;
    localparam int FW        = HDR_W + AW_WIDE + DW;
    localparam int CNT_W     = $clog2(FW + 1);

    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_WREN  = 2'b01,
        OP_WRITE = 2'b10,
        OP_ERASE = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_GAP,
        ST_POLL,
        ST_FIN
    } st_e;

    typedef struct packed {
        op_e                 op;
        logic [AW_WIDE-1:0]  addr;
        logic [DW-1:0]       data;
        logic                wide;
    } req_t;

    function automatic logic [1:0] opcode(op_e op);
        case (op)
            OP_READ:  return 2'b10;
            OP_WREN:  return 2'b00;
            OP_WRITE: return 2'b01;
            default:  return 2'b11;
        endcase
    endfunction

    function automatic logic is_prog(op_e op);
        return (op == OP_WRITE) || (op == OP_ERASE);
    endfunction

    function automatic logic has_data(op_e op);
        return (op == OP_WRITE) || (op == OP_READ);
    endfunction

    // Left-aligned frame: header, address, then the data word for writes.
    function automatic logic [FW-1:0] build_frame(req_t r);
        logic [FW-1:0]      f;
        logic [AW_WIDE-1:0] a;
        a = (r.op == OP_WREN) ? {AW_WIDE{1'b1}} : r.addr;
        f = '0;
        f[FW-1 -: HDR_W] = {1'b1, opcode(r.op)};
        if (r.wide) begin
            f[FW-1-HDR_W -: AW_WIDE] = a;
            if (r.op == OP_WRITE)
                f[FW-1-HDR_W-AW_WIDE -: DW] = r.data;
        end else begin
            f[FW-1-HDR_W -: AW_NARROW] = a[AW_NARROW-1:0];
            if (r.op == OP_WRITE)
                f[FW-1-HDR_W-AW_NARROW -: DW] = r.data;
        end
        return f;
    endfunction

    function automatic logic [CNT_W-1:0] frame_len(req_t r);
        int n;
        n = HDR_W + (r.wide ? AW_WIDE : AW_NARROW) + (has_data(r.op) ? DW : 0);
        return CNT_W'(n);
    endfunction

endpackage

// File: rtl/sprom_tick.sv
module sprom_tick #(
    parameter int PHASE_CYC = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);
    localparam int CW = $clog2(PHASE_CYC);
    localparam logic [CW-1:0] LAST = CW'(PHASE_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en)
            cnt <= '0;
        else if (cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = en && (cnt == LAST);
endmodule

// File: rtl/sprom_poll.sv
module sprom_poll #(
    parameter int POLL_CYC = 500000,
    parameter int POLL_MAX = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic miso,
    output logic ready,
    output logic expired
);
    localparam int TW = $clog2(POLL_CYC);
    localparam int NW = $clog2(POLL_MAX + 1);
    localparam logic [TW-1:0] T_LAST = TW'(POLL_CYC - 1);
    localparam logic [NW-1:0] N_LAST = NW'(POLL_MAX - 1);

    logic [TW-1:0] tmr;
    logic [NW-1:0] nchk;
    logic          slot;

    assign slot = run && (tmr == T_LAST);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            tmr  <= '0;
            nchk <= '0;
        end else if (slot) begin
            tmr  <= '0;
            nchk <= nchk + 1'b1;
        end else begin
            tmr <= tmr + 1'b1;
        end
    end

    assign ready   = slot && miso;
    assign expired = slot && !miso && (nchk == N_LAST);
endmodule

// File: rtl/sprom_shreg.sv
module sprom_shreg #(
    parameter int FW = 27,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [FW-1:0] frame,
    input  logic          shift,
    input  logic          cap,
    input  logic          sin,
    output logic          sout,
    output logic [DW-1:0] word
);
    logic [FW-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr   <= '0;
            word <= '0;
        end else begin
            if (load)
                sr <= frame;
            else if (shift)
                sr <= {sr[FW-2:0], 1'b0};
            if (cap)
                word <= {word[DW-2:0], sin};
        end
    end

    assign sout = sr[FW-1];
endmodule

// File: rtl/sprom_ctrl.sv
module sprom_ctrl
    import sprom_pkg::*;
#(
    parameter int PHASE_CYC = 50,
    parameter int POLL_CYC  = 500000,
    parameter int POLL_MAX  = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [1:0]         req_op,
    input  logic [AW_WIDE-1:0] req_addr,
    input  logic [DW-1:0]      req_wdata,
    input  logic               addr_wide,
    output logic               req_ack,
    output logic               busy,
    output logic               done,
    output logic               timeout,
    output logic [DW-1:0]      rdata,
    output logic               rom_sel,
    output logic               rom_sclk,
    output logic               rom_mosi,
    input  logic               rom_miso
);
    st_e              st;
    op_e              cur_op;
    logic [CNT_W-1:0] left;
    req_t             in_req;
    logic             accept;
    logic             tick;
    logic             tick_en;
    logic             p_run, p_ready, p_expired;
    logic             shift, cap, sout;

    always_comb begin
        in_req.op   = op_e'(req_op);
        in_req.addr = req_addr;
        in_req.data = req_wdata;
        in_req.wide = addr_wide;
    end

    assign accept  = (st == ST_IDLE) && req_valid;
    assign req_ack = accept;
    assign busy    = (st != ST_IDLE);

    assign tick_en = (st == ST_LOW) || (st == ST_HIGH) || (st == ST_GAP) || (st == ST_FIN);
    assign p_run   = (st == ST_POLL);
    assign shift   = (st == ST_HIGH) && tick;
    assign cap     = shift && (cur_op == OP_READ) && (left <= CNT_W'(DW));

    sprom_tick #(.PHASE_CYC(PHASE_CYC)) i_tick (
        .clk  (clk),
        .rst  (rst),
        .en   (tick_en),
        .tick (tick)
    );

    sprom_poll #(.POLL_CYC(POLL_CYC), .POLL_MAX(POLL_MAX)) i_poll (
        .clk     (clk),
        .rst     (rst),
        .run     (p_run),
        .miso    (rom_miso),
        .ready   (p_ready),
        .expired (p_expired)
    );

    sprom_shreg #(.FW(FW), .DW(DW)) i_shreg (
        .clk   (clk),
        .rst   (rst),
        .load  (accept),
        .frame (build_frame(in_req)),
        .shift (shift),
        .cap   (cap),
        .sin   (rom_miso),
        .sout  (sout),
        .word  (rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            cur_op  <= OP_READ;
            left    <= '0;
            done    <= 1'b0;
            timeout <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (accept) begin
                        cur_op  <= in_req.op;
                        left    <= frame_len(in_req);
                        timeout <= 1'b0;
                        st      <= ST_LOW;
                    end
                end
                ST_LOW: begin
                    if (tick)
                        st <= ST_HIGH;
                end
                ST_HIGH: begin
                    if (tick) begin
                        left <= left - 1'b1;
                        if (left == CNT_W'(1))
                            st <= is_prog(cur_op) ? ST_GAP : ST_FIN;
                        else
                            st <= ST_LOW;
                    end
                end
                ST_GAP: begin
                    if (tick)
                        st <= ST_POLL;
                end
                ST_POLL: begin
                    if (p_ready) begin
                        st <= ST_FIN;
                    end else if (p_expired) begin
                        timeout <= 1'b1;
                        st      <= ST_FIN;
                    end
                end
                ST_FIN: begin
                    if (tick) begin
                        st   <= ST_IDLE;
                        done <= 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign rom_sel  = (st == ST_LOW) || (st == ST_HIGH) || (st == ST_POLL);
    assign rom_sclk = (st == ST_HIGH);
    assign rom_mosi = ((st == ST_LOW) || (st == ST_HIGH)) && sout;
endmodule

// File: rtl/sprom_chk.sv
module sprom_chk #(
    parameter int PHASE_CYC = 50
) (
    input logic clk,
    input logic rst,
    input logic req_ack,
    input logic busy,
    input logic done,
    input logic timeout,
    input logic rom_sel,
    input logic rom_sclk,
    input logic rom_mosi
);
    logic        sk_q;
    logic        mosi_q;
    logic [31:0] run_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            sk_q    <= 1'b0;
            mosi_q  <= 1'b0;
            run_len <= 32'd1;
        end else begin
            sk_q   <= rom_sclk;
            mosi_q <= rom_mosi;
            if (rom_sclk != sk_q)
                run_len <= 32'd1;
            else if (run_len != '1)
                run_len <= run_len + 32'd1;
        end
    end

    // R5
    high_phase_len_chk: assert property (@(posedge clk) disable iff (rst)
        (sk_q && !rom_sclk) |-> (run_len == 32'(PHASE_CYC)));

    // R5
    low_phase_len_chk: assert property (@(posedge clk) disable iff (rst)
        (!sk_q && rom_sclk) |-> (run_len >= 32'(PHASE_CYC)));

    // R5
    mosi_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rom_sclk && sk_q) |-> (rom_mosi == mosi_q));

    // R6
    done_sel_low_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !rom_sel);

    // R9
    ack_then_busy_chk: assert property (@(posedge clk) disable iff (rst)
        req_ack |=> busy);

    // R9
    no_ack_busy_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !req_ack);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    timeout_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(timeout) |-> (busy && !rom_sel));
endmodule

bind sprom_ctrl sprom_chk #(.PHASE_CYC(PHASE_CYC)) i_sprom_chk (
    .clk      (clk),
    .rst      (rst),
    .req_ack  (req_ack),
    .busy     (busy),
    .done     (done),
    .timeout  (timeout),
    .rom_sel  (rom_sel),
    .rom_sclk (rom_sclk),
    .rom_mosi (rom_mosi)
);

// File: tb/test_sprom_ctrl.sv
module test_sprom_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int PH   = 3;
    localparam int PCYC = 20;
    localparam int PMAX = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [7:0]  req_addr = 8'd0;
    logic [15:0] req_wdata = 16'd0;
    logic        addr_wide = 1'b0;
    logic        req_ack, busy, done, timeout;
    logic [15:0] rdata;
    logic        rom_sel, rom_sclk, rom_mosi;
    logic        rom_miso = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sprom_ctrl #(.PHASE_CYC(PH), .POLL_CYC(PCYC), .POLL_MAX(PMAX)) i_sprom_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .addr_wide(addr_wide),
        .req_ack(req_ack), .busy(busy), .done(done), .timeout(timeout),
        .rdata(rdata), .rom_sel(rom_sel), .rom_sclk(rom_sclk),
        .rom_mosi(rom_mosi), .rom_miso(rom_miso)
    );

    // Device model state
    int          m_ncmd = 0, m_total = 0, m_delay = 0;
    bit          m_read = 0, m_prog = 0;
    logic [15:0] m_rdword = 16'd0;
    bit          cap_bits [64];
    int          nb = 0, cyc = 0, tstart = 0, plen = 0, gap = 0, sel_rises = 0;
    int          hi_len = 0, lo_len = 0;
    bit          in_gap = 0, armed = 0, tvalid = 0, phase_bad = 0;
    logic        sk_p = 0, sel_p = 0, di_p = 0;

    bit exp_bits [64];
    int exp_n = 0;

    always @(negedge clk) begin
        cyc++;
        if (rom_sel && !sel_p) begin
            sel_rises++;
            lo_len = 0;
        end
        if (rom_sel && rom_sclk && !sk_p) begin
            if (lo_len != PH) phase_bad = 1;
            lo_len = 0;
            if (nb < 64) cap_bits[nb] = rom_mosi;
            if (m_read && nb >= m_ncmd && nb < m_ncmd + 16)
                rom_miso = m_rdword[15 - (nb - m_ncmd)];
            nb++;
        end
        if (rom_sel && !rom_sclk) lo_len++;
        if (rom_sclk) hi_len++;
        if (!rom_sclk && sk_p) begin
            if (hi_len != PH) phase_bad = 1;
            hi_len = 0;
        end
        if (rom_sclk && sk_p && rom_mosi != di_p) phase_bad = 1;
        if (!rom_sel && sel_p && m_prog && nb == m_total && !armed && !in_gap && !tvalid) begin
            in_gap = 1; gap = 0; tstart = cyc; tvalid = 1;
        end
        if (in_gap && !rom_sel) gap++;
        if (in_gap && rom_sel) begin in_gap = 0; armed = 1; end
        if (armed && rom_sel) plen++;
        if (armed && !rom_sel) armed = 0;
        if (m_prog) rom_miso = tvalid && ((cyc - tstart) >= m_delay);
        sk_p = rom_sclk; sel_p = rom_sel; di_p = rom_mosi;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic push_bit(input bit b);
        exp_bits[exp_n] = b;
        exp_n++;
    endtask

    // Issue one request, wait for done, compare the frame and the pin timing.
    task automatic run_cmd(input logic [1:0] op, input logic [7:0] addr,
                           input logic [15:0] wd, input bit wide,
                           input logic [15:0] rdw, input int delay,
                           input bit noisy, input string freq);
        int aw;
        int w;
        int mism;
        bit ack_bad;
        aw = wide ? 8 : 6;
        exp_n = 0;
        push_bit(1'b1);
        case (op)
            2'd0: begin push_bit(1); push_bit(0); end
            2'd1: begin push_bit(0); push_bit(0); end
            2'd2: begin push_bit(0); push_bit(1); end
            default: begin push_bit(1); push_bit(1); end
        endcase
        for (int i = aw - 1; i >= 0; i--) push_bit((op == 2'd1) ? 1'b1 : addr[i]);
        if (op == 2'd2) for (int i = 15; i >= 0; i--) push_bit(wd[i]);
        if (op == 2'd0) for (int i = 0; i < 16; i++) push_bit(1'b0);

        @(negedge clk);
        m_ncmd = 3 + aw; m_total = exp_n; m_read = (op == 2'd0);
        m_prog = (op >= 2'd2); m_rdword = rdw; m_delay = delay;
        nb = 0; plen = 0; gap = 0; sel_rises = 0; phase_bad = 0;
        in_gap = 0; armed = 0; tvalid = 0;
        req_op = op; req_addr = addr; req_wdata = wd; addr_wide = wide;
        req_valid = 1'b1;
        #1;
        chk(req_ack === 1'b1, "R9", "ack while idle", req_ack, 1);
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy === 1'b1, "R9", "busy after accept", busy, 1);
        w = 0;
        ack_bad = 0;
        while (done !== 1'b1 && w < 5000) begin
            if (noisy) begin
                req_valid = busy; req_op = ~op; req_addr = ~addr;
                req_wdata = ~wd; addr_wide = ~wide;
                #1;
                if (busy && req_ack) ack_bad = 1;
            end
            @(negedge clk);
            w++;
        end
        req_valid = 1'b0;
        chk(w < 5000, "R9", "done reached", w, 0);
        if (noisy) chk(!ack_bad, "R9", "no ack while busy", ack_bad, 0);
        chk(rom_sel === 1'b0, "R6", "select low at done", rom_sel, 0);
        chk(busy === 1'b0, "R9", "idle at done", busy, 0);
        mism = 0;
        for (int i = 0; i < exp_n; i++) if (cap_bits[i] != exp_bits[i]) mism++;
        chk(nb == exp_n, freq, "frame bit count", nb, exp_n);
        chk(mism == 0, freq, "frame bit mismatches", mism, 0);
        chk(!phase_bad, "R5", "phase lengths and data hold", phase_bad, 0);
        chk(sel_rises == (m_prog ? 2 : 1), "R6", "select rises", sel_rises, m_prog ? 2 : 1);
        @(negedge clk);
        chk(done === 1'b0, "R9", "done one cycle", done, 0);
    endtask

    task automatic t_reset();
        chk(rom_sel === 1'b0,  "R10", "sel after reset", rom_sel, 0);
        chk(rom_sclk === 1'b0, "R10", "sclk after reset", rom_sclk, 0);
        chk(rom_mosi === 1'b0, "R10", "mosi after reset", rom_mosi, 0);
        chk(busy === 1'b0,     "R10", "busy after reset", busy, 0);
        chk(done === 1'b0,     "R10", "done after reset", done, 0);
        chk(timeout === 1'b0,  "R10", "timeout after reset", timeout, 0);
    endtask

    task automatic t_read_wide();
        run_cmd(2'd0, 8'hA5, 16'h0000, 1'b1, 16'hC33C, 0, 1'b1, "R1");
        chk(rdata == 16'hC33C, "R4", "read word wide", rdata, 16'hC33C);
        chk(timeout === 1'b0, "R4", "no timeout on read", timeout, 0);
    endtask

    task automatic t_read_narrow();
        run_cmd(2'd0, 8'hEB, 16'h0000, 1'b0, 16'h8001, 0, 1'b0, "R1");
        chk(rdata == 16'h8001, "R4", "read word narrow", rdata, 16'h8001);
    endtask

    task automatic t_wren();
        run_cmd(2'd1, 8'h12, 16'h0000, 1'b0, 16'h0, 0, 1'b0, "R2");
        run_cmd(2'd1, 8'h00, 16'hFFFF, 1'b1, 16'h0, 0, 1'b0, "R2");
        chk(plen == 0, "R2", "no polling after enable", plen, 0);
    endtask

    task automatic t_write_poll();
        run_cmd(2'd2, 8'h3C, 16'hBEEF, 1'b1, 16'h0, 45, 1'b0, "R3");
        chk(gap == PH, "R7", "select low gap", gap, PH);
        chk(plen == 3 * PCYC, "R7", "poll length three intervals", plen, 3 * PCYC);
        chk(timeout === 1'b0, "R7", "no timeout", timeout, 0);
    endtask

    task automatic t_write_fast();
        run_cmd(2'd2, 8'h15, 16'h1234, 1'b0, 16'h0, 0, 1'b0, "R3");
        chk(plen == PCYC, "R7", "poll length one interval", plen, PCYC);
        chk(timeout === 1'b0, "R7", "no timeout fast", timeout, 0);
    endtask

    task automatic t_erase_timeout();
        run_cmd(2'd3, 8'h81, 16'h0000, 1'b1, 16'h0, 1000000000, 1'b0, "R1");
        chk(plen == PMAX * PCYC, "R8", "poll length at limit", plen, PMAX * PCYC);
        chk(timeout === 1'b1, "R8", "timeout set", timeout, 1);
        repeat (5) @(negedge clk);
        chk(timeout === 1'b1, "R8", "timeout held", timeout, 1);
    endtask

    task automatic t_read_after_timeout();
        run_cmd(2'd0, 8'h2A, 16'h0000, 1'b0, 16'h5A0F, 0, 1'b0, "R1");
        chk(timeout === 1'b0, "R8", "timeout cleared by next request", timeout, 0);
        chk(rdata == 16'h5A0F, "R4", "read after timeout", rdata, 16'h5A0F);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_read_wide();
        t_read_narrow();
        t_wren();
        t_write_poll();
        t_write_fast();
        t_erase_timeout();
        t_read_after_timeout();
        repeat (5) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule